// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one burst request into the sequence of column addresses that a memory device visits during a read or write burst. A request is a single-cycle start pulse carrying a start column, a three-bit burst-length code and an ordering bit. From the next cycle onward the block presents one column per cycle with a valid strobe. It raises a last-beat flag on the final column of the burst.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned column block whose size equals the burst length and which holds the start column. When the address reaches the edge of that block it wraps back inside it. The visiting order is either sequential or interleaved. A full-page burst steps through every column of the page and wraps at the end of the page. It keeps running until the terminate input stops it. Terminate also cuts a fixed burst short.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held and in the first cycle after release, `beat_valid_o`, `beat_last_o` and `cfg_err_o` are low.
- R2: A start pulse accepted at a clock edge makes `beat_valid_o` high in the following cycle, with `beat_col_o` equal to the start column. Later beats follow on consecutive cycles without gaps.
- R3: Length codes 3'b000, 3'b001, 3'b010 and 3'b011 give bursts of 1, 2, 4 and 8 beats. `beat_last_o` is high only on the final beat, and `beat_valid_o` is low in the cycle after it.
- R4: With `order_il_i`=0 and burst length N, beat k carries the start column with its low log2(N) bits replaced by (start + k) mod N. The upper bits never change.
- R5: With `order_il_i`=1 and burst length N, beat k carries the start column with its low log2(N) bits XORed with k.
- R6: Code 3'b111 with `order_il_i`=0 selects a full-page burst. Beat k carries (start + k) mod 2^COL_W, and the burst continues past 2^COL_W beats until terminated.
- R7: When `term_i` is high during a valid beat, `beat_last_o` is high on that same beat and no further beat follows.
- R8: A start with a code from 3'b100 to 3'b110, or with code 3'b111 together with `order_il_i`=1, produces no beat. `cfg_err_o` is high for exactly the following cycle, and any burst in progress is stopped.
- R9: A start pulse during an active burst abandons it. The next cycle carries beat 0 of the new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle burst request |
| start_col_i | input | COL_W | Start column of the request |
| len_code_i | input | 3 | Burst-length code |
| order_il_i | input | 1 | 1 selects interleaved order, 0 sequential |
| term_i | input | 1 | Ends the active burst on the current beat |
| beat_col_o | output | COL_W | Column address of the current beat |
| beat_valid_o | output | 1 | A beat is presented this cycle |
| beat_last_o | output | 1 | Current beat is the final one |
| cfg_err_o | output | 1 | Previous start was refused |

## Verification
The assertions run on every cycle. They check that a good start yields its start column on the next cycle and that a refused start yields an error pulse with no beat. They also check that the last flag only appears on a valid beat and that nothing follows the last beat, and that consecutive beats of a fixed burst keep the upper column bits. The wrap point inside each block, the interleaved visiting order, full-page wrap past the page end, and the exact beat counts for each code can only be shown by the bench's scenarios. The bench compares every beat of random and directed bursts against independently computed columns.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
    localparam int LEN_CODE_W = 3;

    localparam logic [LEN_CODE_W-1:0] LEN_ONE   = 3'b000;
    localparam logic [LEN_CODE_W-1:0] LEN_TWO   = 3'b001;
    localparam logic [LEN_CODE_W-1:0] LEN_FOUR  = 3'b010;
    localparam logic [LEN_CODE_W-1:0] LEN_EIGHT = 3'b011;
    localparam logic [LEN_CODE_W-1:0] LEN_PAGE  = 3'b111;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
    import burst_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [LEN_CODE_W-1:0] code_i,
    input  logic                  il_i,
    output logic [COL_W-1:0]      mask_o,
    output logic                  page_o,
    output logic                  bad_o
);
    always_comb begin
        mask_o = '0;
        page_o = 1'b0;
        bad_o  = 1'b0;
        unique case (code_i)
            LEN_ONE:   mask_o = COL_W'(0);
            LEN_TWO:   mask_o = COL_W'(1);
            LEN_FOUR:  mask_o = COL_W'(3);
            LEN_EIGHT: mask_o = COL_W'(7);
            LEN_PAGE: begin
                mask_o = '1;
                page_o = 1'b1;
                bad_o  = il_i;
            end
            default:   bad_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/burst_order.sv
module burst_order #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] idx_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             il_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] low_seq;
    logic [COL_W-1:0] low_il;

    always_comb begin
        low_seq = base_i + idx_i;
        low_il  = base_i ^ idx_i;
        col_o   = (base_i & ~mask_i) | ((il_i ? low_il : low_seq) & mask_i);
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [COL_W-1:0]      start_col_i,
    input  logic [LEN_CODE_W-1:0] len_code_i,
    input  logic                  order_il_i,
    input  logic                  term_i,
    output logic [COL_W-1:0]      beat_col_o,
    output logic                  beat_valid_o,
    output logic                  beat_last_o,
    output logic                  cfg_err_o
);
    typedef struct packed {
        logic             act;
        logic             err;
        logic             il;
        logic             page;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] idx;
        logic [COL_W-1:0] mask;
    } gen_state_t;

    gen_state_t st_d, st_q;

    logic [COL_W-1:0] req_mask;
    logic             req_page;
    logic             req_bad;

    burst_len_decode #(.COL_W(COL_W)) u_decode (
        .code_i (len_code_i),
        .il_i   (order_il_i),
        .mask_o (req_mask),
        .page_o (req_page),
        .bad_o  (req_bad)
    );

    burst_order #(.COL_W(COL_W)) u_order (
        .base_i (st_q.base),
        .idx_i  (st_q.idx),
        .mask_i (st_q.mask),
        .il_i   (st_q.il),
        .col_o  (beat_col_o)
    );

    logic at_end;
    assign at_end       = !st_q.page && (st_q.idx == st_q.mask);
    assign beat_valid_o = st_q.act;
    assign beat_last_o  = st_q.act && (term_i || at_end);
    assign cfg_err_o    = st_q.err;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (start_i) begin
            if (req_bad) begin
                st_d.act = 1'b0;
                st_d.err = 1'b1;
            end else begin
                st_d.act  = 1'b1;
                st_d.il   = order_il_i;
                st_d.page = req_page;
                st_d.base = start_col_i;
                st_d.mask = req_mask;
                st_d.idx  = '0;
            end
        end else if (st_q.act) begin
            if (beat_last_o) begin
                st_d.act = 1'b0;
            end else begin
                st_d.idx = st_q.idx + COL_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !req_bad) |=> (beat_valid_o && beat_col_o == $past(start_col_i)));

    // R8
    refused_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && req_bad) |=> (cfg_err_o && !beat_valid_o));

    // R7
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last_o |-> beat_valid_o);

    // R3
    nothing_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_last_o && !start_i) |=> !beat_valid_o);

    // R4
    block_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && !beat_last_o && !start_i && !st_q.page) |=>
            ((beat_col_o & ~st_q.mask) == ($past(beat_col_o) & ~st_q.mask)));

    // R8
    err_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> !beat_valid_o);
endmodule

// File: tb/burst_col_gen_bench.sv
`timescale 1ns/1ps
module burst_col_gen_bench;
    localparam int COL_W = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       len_code_i = '0;
    logic             order_il_i = 1'b0;
    logic             term_i = 1'b0;
    logic [COL_W-1:0] beat_col_o;
    logic             beat_valid_o;
    logic             beat_last_o;
    logic             cfg_err_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) u_burst_col_gen (
        .clk, .rst_n, .start_i, .start_col_i, .len_code_i,
        .order_il_i, .term_i, .beat_col_o, .beat_valid_o,
        .beat_last_o, .cfg_err_o
    );

    function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s,
            input logic [2:0] c, input logic il, input int k);
        int n;
        logic [COL_W-1:0] m, kk;
        kk = COL_W'(k);
        if (c == 3'b111) return s + kk;
        n = 1 << c;
        m = COL_W'(n - 1);
        return (s & ~m) | ((il ? (s ^ kk) : (s + kk)) & m);
    endfunction

    function automatic int beat_count(input logic [2:0] c);
        return (c == 3'b111) ? 0 : (1 << c);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [COL_W-1:0] col, input logic [2:0] c, input logic il);
        start_i = 1'b1;
        start_col_i = col;
        len_code_i = c;
        order_il_i = il;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Runs a whole burst; term_at < 0 means no terminate.
    task automatic run_burst(input logic [COL_W-1:0] col, input logic [2:0] c,
            input logic il, input int term_at, input string req);
        int n;
        int lastk;
        @(negedge clk);
        issue(col, c, il);
        n = beat_count(c);
        lastk = (n == 0) ? term_at : n - 1;
        if (term_at >= 0 && term_at < lastk) lastk = term_at;
        for (int k = 0; k <= lastk; k++) begin
            term_i = (k == term_at);
            #0.5;
            chk(req, "valid", int'(beat_valid_o), 1);
            chk(req, "col", int'(beat_col_o), int'(exp_col(col, c, il, k)));
            chk(req, "last", int'(beat_last_o), int'(k == lastk));
            @(negedge clk);
            term_i = 1'b0;
        end
        chk(req, "valid after last", int'(beat_valid_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [2:0] c;
        logic il;
        int t;
        void'($urandom(32'd1234));
        #1;
        chk("R1", "valid in reset", int'(beat_valid_o), 0);
        chk("R1", "err in reset", int'(cfg_err_o), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "valid after reset", int'(beat_valid_o), 0);
        chk("R1", "last after reset", int'(beat_last_o), 0);
        chk("R1", "err after reset", int'(cfg_err_o), 0);

        // Directed wrap cases: R2 R3 R4 R5
        run_burst(9'd6, 3'b010, 1'b0, -1, "R4");
        run_burst(9'd13, 3'b011, 1'b0, -1, "R4");
        run_burst(9'd13, 3'b011, 1'b1, -1, "R5");
        run_burst(9'd7, 3'b001, 1'b1, -1, "R5");
        run_burst(9'd100, 3'b000, 1'b0, -1, "R3");
        // R6: full page across the page end, then beyond one full page
        run_burst(9'd510, 3'b111, 1'b0, 5, "R6");
        run_burst(9'd3, 3'b111, 1'b0, 520, "R6");
        // R7: terminate a fixed burst early
        run_burst(9'd40, 3'b011, 1'b0, 2, "R7");

        // R8: reserved code and interleaved full page
        for (int r = 4; r <= 7; r++) begin
            @(negedge clk);
            issue(9'd5, 3'(r), (r == 7));
            chk("R8", "err pulse", int'(cfg_err_o), 1);
            chk("R8", "no beat", int'(beat_valid_o), 0);
            @(negedge clk);
            chk("R8", "err one cycle", int'(cfg_err_o), 0);
            chk("R8", "still no beat", int'(beat_valid_o), 0);
        end

        // R9: restart during an active burst
        @(negedge clk);
        issue(9'd3, 3'b011, 1'b0);
        @(negedge clk);
        chk("R9", "old beat1", int'(beat_col_o), 4);
        issue(9'd21, 3'b010, 1'b1);
        for (int k = 0; k < 4; k++) begin
            #0.5;
            chk("R9", "new col", int'(beat_col_o), int'(exp_col(9'd21, 3'b010, 1'b1, k)));
            chk("R9", "new last", int'(beat_last_o), int'(k == 3));
            @(negedge clk);
        end
        chk("R9", "ended", int'(beat_valid_o), 0);

        // R8: refused start stops an active burst
        issue(9'd50, 3'b011, 1'b0);
        issue(9'd0, 3'b101, 1'b0);
        chk("R8", "abort err", int'(cfg_err_o), 1);
        chk("R8", "abort no beat", int'(beat_valid_o), 0);
        @(negedge clk);
        chk("R8", "stays stopped", int'(beat_valid_o), 0);

        // Random bursts
        for (int i = 0; i < 300; i++) begin
            t = $urandom_range(0, 4);
            c = (t == 4) ? 3'b111 : 3'(t);
            il = (c == 3'b111) ? 1'b0 : 1'($urandom_range(0, 1));
            if (c == 3'b111) t = $urandom_range(0, 20);
            else t = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 7) : -1;
            run_burst(COL_W'($urandom), c, il, t, il ? "R5" : "R4");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule